// File: doc/BRIEF.md
# Lock-Aware Output Pin Controller

This block drives a small group of general-purpose output pins from register settings, and raises an interrupt from the lock status of a clock synthesizer. Each pin has a 4-bit function field. The field can force the pin low, force it high, or pass the raw lock status input straight to the pin. Any other field value leaves the pin undriven. Pin drive also depends on a shared tri-state bit and on two routing bits. The first pin needs an alternate-select bit set. The upper pins need an interface-select bit cleared. The pull-up and pull-down controls for each pin are held in a register and passed straight to the pad ring.

The interrupt path works on its own copy of the lock signal. This copy can be inverted by a polarity bit. The inverted signal goes through a two-flop synchronizer, and a rising edge at the synchronizer output sets a sticky status bit. Software clears the status bit by writing one to it. The interrupt line is the status bit gated by an enable bit. Polarity inversion affects only the interrupt path, never the pin output.

Top module: `gpio_lock_mux`

## Requirements
- R1: After reset all readable registers return 0, every `pin_oe` bit is 0, `pin_pu`/`pin_pd` are 0 and `irq` is 0.
- R2: A pin whose function field (address 0, pin i at bits [4i+3:4i]) holds 4'b0010 has `pin_oe`=1 and `pin_out`=0 when its routing allows drive.
- R3: A function field of 4'b0011 gives `pin_oe`=1 and `pin_out`=1 when routing allows drive.
- R4: A function field of 4'b0100 drives `pin_out` with `lock_in` in the same cycle, 1 meaning locked. The polarity bit (address 2 bit 3) never inverts this value.
- R5: Any other function field value keeps that pin's `pin_oe` at 0.
- R6: Tri-state bit (address 2 bit 0) = 1 forces every `pin_oe` to 0.
- R7: Pin 0 drives only when alternate-select (address 2 bit 1) is 1. Pins 2 to 4 drive only when interface-select (address 2 bit 2) is 0. Pin 1 needs neither.
- R8: `pin_pu` follows address 1 bits [4:0], and `pin_pd` follows address 1 bits [9:5].
- R9: A rising edge of `lock_in` XOR polarity bit sets the sticky status (address 3 bit 0) on the third rising clock edge after the change, and not before. A falling edge does not set it.
- R10: Writing address 3 with bit 0 = 1 clears the status. Writing bit 0 = 0 leaves it unchanged. A set falling in the same cycle as a clear wins.
- R11: `irq` = status AND enable (address 2 bit 4). The status remains readable while the interrupt is masked.
- R12: Address 3 bit 1 reads the synchronized, polarity-adjusted lock level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on `reg_addr` |
| lock_in | input | 1 | Raw lock status, 1 = locked |
| pin_out | output | 5 | Per-pin output value |
| pin_oe | output | 5 | Per-pin output enable |
| pin_pu | output | 5 | Per-pin pull-up control |
| pin_pd | output | 5 | Per-pin pull-down control |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle: the synchronized rising edge that sets the sticky status, and a software write-one-to-clear of that status. The bench raises `lock_in` on a falling clock edge and issues the clearing write so that it commits on the third rising edge, the same edge on which the set lands. The status must then read 1 and `irq` must stay high. A later clear with no edge pending must then bring the status to 0.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
   localparam int FN_W = 4;

   typedef enum logic [FN_W-1:0] {
      FN_LOW  = 4'b0010,
      FN_HIGH = 4'b0011,
      FN_LOCK = 4'b0100
   } pin_fn_e;

   localparam int REG_FUNC = 0;
   localparam int REG_PULL = 1;
   localparam int REG_CTRL = 2;
   localparam int REG_STAT = 3;

   localparam int CB_TRI   = 0;
   localparam int CB_ALT   = 1;
   localparam int CB_IFSEL = 2;
   localparam int CB_POL   = 3;
   localparam int CB_IRQEN = 4;
   localparam int CTRL_W   = 5;
endpackage

// File: rtl/gpio_lock_regs.sv
module gpio_lock_regs
   import gpio_lock_pkg::*;
#(
   parameter int NUM_PINS = 5,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   output logic [DATA_W-1:0]        rdata_o,
   input  logic                     sts_i,
   input  logic                     live_i,
   output logic                     clr_o,
   output logic [NUM_PINS*FN_W-1:0] fn_o,
   output logic [NUM_PINS-1:0]      pu_o,
   output logic [NUM_PINS-1:0]      pd_o,
   output logic [CTRL_W-1:0]        ctrl_o
);
   localparam int FN_TOT = NUM_PINS * FN_W;
   localparam int PULL_W = 2 * NUM_PINS;

   logic [FN_TOT-1:0] fn_q;
   logic [PULL_W-1:0] pull_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              hit_fn, hit_pull, hit_ctrl, hit_stat;
   logic              unused_wdata;

   assign hit_fn   = (addr_i == ADDR_W'(REG_FUNC));
   assign hit_pull = (addr_i == ADDR_W'(REG_PULL));
   assign hit_ctrl = (addr_i == ADDR_W'(REG_CTRL));
   assign hit_stat = (addr_i == ADDR_W'(REG_STAT));
   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fn_q   <= '0;
         pull_q <= '0;
         ctrl_q <= '0;
      end else if (we_i) begin
         if (hit_fn)   fn_q   <= wdata_i[FN_TOT-1:0];
         if (hit_pull) pull_q <= wdata_i[PULL_W-1:0];
         if (hit_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      end
   end

   assign clr_o  = we_i && hit_stat && wdata_i[0];
   assign fn_o   = fn_q;
   assign pu_o   = pull_q[NUM_PINS-1:0];
   assign pd_o   = pull_q[PULL_W-1:NUM_PINS];
   assign ctrl_o = ctrl_q;

   always_comb begin
      rdata_o = '0;
      if (hit_fn)   rdata_o[FN_TOT-1:0] = fn_q;
      if (hit_pull) rdata_o[PULL_W-1:0] = pull_q;
      if (hit_ctrl) rdata_o[CTRL_W-1:0] = ctrl_q;
      if (hit_stat) rdata_o[1:0]        = {live_i, sts_i};
   end

   AST_PULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && hit_pull) |=> ({pd_o, pu_o} == $past(wdata_i[PULL_W-1:0]))); // R8
endmodule

// File: rtl/gpio_lock_irq.sv
module gpio_lock_irq #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_i,
   input  logic pol_i,
   input  logic en_i,
   input  logic clr_i,
   output logic sts_o,
   output logic live_o,
   output logic irq_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   sts_q;
   logic                   adj;
   logic                   rise;

   assign adj = lock_i ^ pol_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], adj};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sts_q <= 1'b0;
      else if (rise)  sts_q <= 1'b1;
      else if (clr_i) sts_q <= 1'b0;
   end

   assign sts_o  = sts_q;
   assign live_o = sync_q[SYNC_STAGES-1];
   assign irq_o  = sts_q & en_i;

   AST_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q) |-> $past(rise)); // R9
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q && !clr_i) |=> sts_q); // R10
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> sts_q); // R10
   AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !rise) |=> !sts_q); // R10
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !irq_o); // R11
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_lock_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FN_W-1:0] fn_i,
   input  logic            route_ok_i,
   input  logic            lock_i,
   output logic            pin_o,
   output logic            oe_o
);
   logic known;
   logic level;

   always_comb begin
      known = 1'b1;
      level = 1'b0;
      case (fn_i)
         FN_LOW:  level = 1'b0;
         FN_HIGH: level = 1'b1;
         FN_LOCK: level = lock_i;
         default: known = 1'b0;
      endcase
   end

   assign oe_o  = known & route_ok_i;
   assign pin_o = level;

   AST_LOCK_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_o && fn_i == FN_LOCK) |-> (pin_o == lock_i)); // R4
   AST_UNDEF_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      !(fn_i inside {FN_LOW, FN_HIGH, FN_LOCK}) |-> !oe_o); // R5
endmodule

// File: rtl/gpio_lock_mux.sv
module gpio_lock_mux
   import gpio_lock_pkg::*;
#(
   parameter int NUM_PINS    = 5,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 2,
   parameter int ALT_PIN     = 0,
   parameter int IFACE_FIRST = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic                lock_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_pu,
   output logic [NUM_PINS-1:0] pin_pd,
   output logic                irq
);
   if (NUM_PINS * FN_W > DATA_W) begin : g_bad_fn
      $error("function fields exceed data width");
   end
   if (2 * NUM_PINS > DATA_W) begin : g_bad_pull
      $error("pull fields exceed data width");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("address too narrow for four registers");
   end
   if (ALT_PIN >= NUM_PINS || IFACE_FIRST > NUM_PINS) begin : g_bad_route
      $error("routing pin index out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchronizer needs at least two stages");
   end

   logic [NUM_PINS*FN_W-1:0] fn;
   logic [CTRL_W-1:0]        ctrl;
   logic                     sts, live, clr;
   logic [NUM_PINS-1:0]      route_ok;

   gpio_lock_regs #(
      .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .rdata_o(reg_rdata), .sts_i(sts), .live_i(live),
      .clr_o(clr), .fn_o(fn), .pu_o(pin_pu), .pd_o(pin_pd), .ctrl_o(ctrl)
   );

   gpio_lock_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
      .clk(clk), .rst_n(rst_n), .lock_i(lock_in), .pol_i(ctrl[CB_POL]),
      .en_i(ctrl[CB_IRQEN]), .clr_i(clr), .sts_o(sts), .live_o(live),
      .irq_o(irq)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      if (i == ALT_PIN) begin : g_alt
         assign route_ok[i] = ~ctrl[CB_TRI] & ctrl[CB_ALT];
      end else if (i >= IFACE_FIRST) begin : g_iface
         assign route_ok[i] = ~ctrl[CB_TRI] & ~ctrl[CB_IFSEL];
      end else begin : g_plain
         assign route_ok[i] = ~ctrl[CB_TRI];
      end

      gpio_pin_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .fn_i(fn[i*FN_W +: FN_W]), .route_ok_i(route_ok[i]),
         .lock_i(lock_in), .pin_o(pin_out[i]), .oe_o(pin_oe[i])
      );
   end

   AST_TRI_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[CB_TRI] |-> (pin_oe == '0)); // R6
endmodule

// File: tb/gpio_lock_mux_tb.sv
module gpio_lock_mux_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lock_in = 1'b0;
   logic [4:0]  pin_out, pin_oe, pin_pu, pin_pd;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gpio_lock_mux u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_in(lock_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_pd(pin_pd),
      .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      for (int a = 0; a < 4; a++) rd_chk("R1 read", 2'(a), 32'h0);
      chk("R1 oe", {27'b0, pin_oe}, 32'h0);
      chk("R1 pull", {22'b0, pin_pd, pin_pu}, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_functions();
      lock_in = 1'b0;
      wr(2'd2, 32'h2);
      wr(2'd0, 32'h23432);
      #1;
      chk("R2 R3 oe", {27'b0, pin_oe}, 32'h1F);
      chk("R2 R3 out", {27'b0, pin_out}, 32'h0A);
      lock_in = 1'b1;
      #1;
      chk("R4 lock high", {27'b0, pin_out}, 32'h0E);
      wr(2'd2, 32'hA);
      #1;
      chk("R4 polarity ignored", {27'b0, pin_out}, 32'h0E);
      lock_in = 1'b0;
      #1;
      chk("R4 lock low", {27'b0, pin_out}, 32'h0A);
   endtask

   task automatic t_undefined();
      wr(2'd2, 32'h2);
      wr(2'd0, 32'h8F510);
      #1;
      chk("R5 oe", {27'b0, pin_oe}, 32'h0);
   endtask

   task automatic t_tristate();
      wr(2'd0, 32'h33333);
      wr(2'd2, 32'h3);
      #1;
      chk("R6 oe", {27'b0, pin_oe}, 32'h0);
      wr(2'd2, 32'h2);
      #1;
      chk("R6 released", {27'b0, pin_oe}, 32'h1F);
   endtask

   task automatic t_routing();
      wr(2'd2, 32'h0);
      #1;
      chk("R7 alt off", {27'b0, pin_oe}, 32'h1E);
      wr(2'd2, 32'h6);
      #1;
      chk("R7 iface on", {27'b0, pin_oe}, 32'h03);
   endtask

   task automatic t_pull();
      wr(2'd1, 32'h2A5);
      #1;
      chk("R8 pu", {27'b0, pin_pu}, 32'h05);
      chk("R8 pd", {27'b0, pin_pd}, 32'h15);
   endtask

   task automatic t_irq();
      wr(2'd2, 32'h0);
      lock_in = 1'b0;
      settle();
      wr(2'd3, 32'h1);
      @(negedge clk);
      lock_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rd_chk("R9 not early", 2'd3, 32'h2);
      @(negedge clk);
      rd_chk("R9 R11 set masked", 2'd3, 32'h3);
      chk("R11 masked irq", {31'b0, irq}, 32'h0);
      wr(2'd2, 32'h10);
      #1;
      chk("R11 irq on", {31'b0, irq}, 32'h1);
      wr(2'd3, 32'h0);
      rd_chk("R10 write zero", 2'd3, 32'h3);
      wr(2'd3, 32'h1);
      rd_chk("R10 cleared", 2'd3, 32'h2);
      chk("R10 irq low", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_polarity();
      wr(2'd2, 32'h18);
      settle();
      rd_chk("R12 inverted level", 2'd3, 32'h0);
      rd_chk("R9 no set on fall", 2'd3, 32'h0);
      lock_in = 1'b0;
      settle();
      rd_chk("R9 inverted rise", 2'd3, 32'h3);
      chk("R11 irq inverted", {31'b0, irq}, 32'h1);
      wr(2'd3, 32'h1);
   endtask

   task automatic t_collide();
      wr(2'd2, 32'h10);
      lock_in = 1'b0;
      settle();
      wr(2'd3, 32'h1);
      rd_chk("R10 pre clear", 2'd3, 32'h0);
      @(negedge clk);
      lock_in = 1'b1;
      @(negedge clk);
      wr(2'd3, 32'h1);
      rd_chk("R10 set wins", 2'd3, 32'h3);
      chk("R10 irq held", {31'b0, irq}, 32'h1);
      wr(2'd3, 32'h1);
      rd_chk("R10 later clear", 2'd3, 32'h2);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_functions();
      t_undefined();
      t_tristate();
      t_routing();
      t_pull();
      t_irq();
      t_polarity();
      t_collide();
      finish_run();
   end

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule